// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block fetches a missing translation from page tables held in physical memory. When the translation buffer misses, it hands the walker a virtual page number and a context number. The walker reads the context's root pointer from a context table whose base comes from a register input. It then follows up to three levels of tables, using index fields of 8, 6 and 6 bits taken from the page number. It returns a physical page number and the entry's low flag byte, or it reports a fault that the pipeline turns into a precise trap.

The walker reads memory through a port that allows one outstanding request. A request is a one-cycle pulse with a physical address. The response carries one 32-bit word after any latency of at least one cycle. Table reads are never translated. Only one walk runs at a time. While `busy` is high, new miss requests are ignored, and the requester must hold its miss until `busy` falls.

Top module: `pt_walker`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `mem_req_valid` and `done_valid` are 0.
- R2: When `miss_valid` is high and the walker is idle, `busy` rises on the next clock edge. In that same cycle a read is issued at `ctx_base + 4*miss_ctx`.
- R3: After a pointer entry E fetched at level L (0 = context, 1, 2), the next read goes to `{E[31:8], 8'h00} + 4*idx`. The index is vpn[19:12] for level 1, vpn[11:6] for level 2 and vpn[5:0] for level 3.
- R4: The low two bits of each entry give its kind: 0 invalid, 1 pointer to a table, 2 leaf translation, 3 reserved.
- R5: The walk ends with `done_fault`=1, `done_ppn`=0 and `done_flags`=0 in any of these cases: an invalid or reserved entry at any level, a leaf in the context table, or a pointer at level 3. `done_level` then gives the level of the offending read.
- R6: A leaf at level 3 gives `done_ppn` = E[31:8] and `done_flags` = E[7:0], with `done_fault`=0 and `done_level`=3.
- R7: A leaf at level 1 gives `done_ppn` = {E[31:20], vpn[11:0]}. A leaf at level 2 gives `done_ppn` = {E[31:14], vpn[5:0]}. In both cases `done_flags` = E[7:0].
- R8: While `busy` is high, `miss_valid` has no effect on the walk in progress or its result. `busy` stays high through the `done_valid` cycle and falls on the next edge.
- R9: A walk issues exactly `done_level`+1 reads, and never more than four. Each read waits for the response to the previous one.
- R10: `done_valid` is a one-cycle pulse per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_base | input | 32 | Physical base address of the context table |
| miss_valid | input | 1 | Translation miss request |
| miss_ctx | input | 8 | Context number of the miss |
| miss_vpn | input | 20 | Virtual page number of the miss |
| busy | output | 1 | Walk in progress; misses ignored |
| mem_req_valid | output | 1 | One-cycle memory read request |
| mem_req_addr | output | 32 | Physical read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| done_valid | output | 1 | Walk result pulse |
| done_fault | output | 1 | Walk ended in a page fault |
| done_level | output | 2 | Level of the last read (0 = context table) |
| done_ppn | output | 24 | Physical page number |
| done_flags | output | 8 | Low byte of the leaf entry |

## Verification
The embedded assertions check on every cycle that the read budget is respected and that the read count matches the reported level. They also check that results appear only while busy, as single pulses, that a fault clears the payload, that no leaf is reported at the context level, and that large-region leaves pass the virtual index bits through. Only the bench scenarios show that the right address is fetched at each level and that each entry kind leads to the right outcome at each level. The bench also shows that the composed page number matches a model for every index value, and that a miss held during a walk leaves the result untouched.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  // Kind field held in the two lowest bits of every table word
  typedef enum logic [1:0] {
    KIND_INVALID = 2'd0,
    KIND_POINTER = 2'd1,
    KIND_LEAF    = 2'd2,
    KIND_RSVD    = 2'd3
  } ent_kind_e;

  // What the walker does with a fetched word
  typedef enum logic [1:0] {
    ACT_DESCEND = 2'd0,
    ACT_LEAF    = 2'd1,
    ACT_FAULT   = 2'd2
  } walk_act_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } walk_state_e;

endpackage

// File: rtl/pt_entry_classify.sv
module pt_entry_classify
  import pt_walk_pkg::*;
(
  input  logic [1:0] kind_bits_i,
  input  logic [1:0] lvl_i,
  output walk_act_e  act_o
);

  localparam logic [1:0] LAST_LVL = 2'd3;

  ent_kind_e kind;
  assign kind = ent_kind_e'(kind_bits_i);

  always_comb begin
    unique case (kind)
      KIND_POINTER: act_o = (lvl_i == LAST_LVL) ? ACT_FAULT : ACT_DESCEND;
      KIND_LEAF:    act_o = (lvl_i == 2'd0)     ? ACT_FAULT : ACT_LEAF;
      default:      act_o = ACT_FAULT;
    endcase
  end

endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int AW     = 32,
  parameter int CTX_W  = 8,
  parameter int L1_W   = 8,
  parameter int L2_W   = 6,
  parameter int L3_W   = 6,
  parameter int FLAG_W = 8
) (
  input  logic [AW-1:0]                ctx_base_i,
  input  logic [CTX_W-1:0]             ctx_i,
  input  logic [AW-FLAG_W-1:0]         tbl_hi_i,
  input  logic [L1_W+L2_W+L3_W-1:0]    vpn_i,
  input  logic [1:0]                   next_lvl_i,
  output logic [AW-1:0]                ctx_addr_o,
  output logic [AW-1:0]                tbl_addr_o
);

  localparam int VPN_W  = L1_W + L2_W + L3_W;
  localparam int WORD_SH = 2;

  logic [AW-1:0] idx;
  logic [AW-1:0] tbl_base;

  always_comb begin
    unique case (next_lvl_i)
      2'd1:    idx = AW'(vpn_i[VPN_W-1 -: L1_W]);
      2'd2:    idx = AW'(vpn_i[L3_W +: L2_W]);
      default: idx = AW'(vpn_i[L3_W-1:0]);
    endcase
  end

  assign tbl_base   = {tbl_hi_i, {FLAG_W{1'b0}}};
  assign tbl_addr_o = tbl_base + (idx << WORD_SH);
  assign ctx_addr_o = ctx_base_i + (AW'(ctx_i) << WORD_SH);

endmodule

// File: rtl/pt_ppn_compose.sv
module pt_ppn_compose #(
  parameter int PPN_W = 24,
  parameter int L2_W  = 6,
  parameter int L3_W  = 6
) (
  input  logic [PPN_W-1:0]     leaf_ppn_i,
  input  logic [L2_W+L3_W-1:0] vpn_lo_i,
  input  logic [1:0]           lvl_i,
  output logic [PPN_W-1:0]     ppn_o
);

  localparam int LO_W = L2_W + L3_W;

  // Bits below a level's reach come from the virtual page number
  for (genvar b = 0; b < PPN_W; b++) begin : g_bit
    if (b < L3_W) begin : g_l3
      assign ppn_o[b] = (lvl_i == 2'd3) ? leaf_ppn_i[b] : vpn_lo_i[b];
    end else if (b < LO_W) begin : g_l2
      assign ppn_o[b] = (lvl_i >= 2'd2) ? leaf_ppn_i[b] : vpn_lo_i[b];
    end else begin : g_hi
      assign ppn_o[b] = leaf_ppn_i[b];
    end
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CTX_W  = 8,
  parameter int L1_W   = 8,
  parameter int L2_W   = 6,
  parameter int L3_W   = 6,
  parameter int FLAG_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [AW-1:0]              ctx_base,
  input  logic                       miss_valid,
  input  logic [CTX_W-1:0]           miss_ctx,
  input  logic [L1_W+L2_W+L3_W-1:0]  miss_vpn,
  output logic                       busy,
  output logic                       mem_req_valid,
  output logic [AW-1:0]              mem_req_addr,
  input  logic                       mem_rsp_valid,
  input  logic [AW-1:0]              mem_rsp_data,
  output logic                       done_valid,
  output logic                       done_fault,
  output logic [1:0]                 done_level,
  output logic [AW-FLAG_W-1:0]       done_ppn,
  output logic [FLAG_W-1:0]          done_flags
);

  localparam int VPN_W    = L1_W + L2_W + L3_W;
  localparam int PPN_W    = AW - FLAG_W;
  localparam int LO_W     = L2_W + L3_W;
  localparam int MAX_RD   = 4;
  localparam int CNT_W    = $clog2(MAX_RD + 1);

  walk_state_e        state_q;
  logic [VPN_W-1:0]   vpn_q;
  logic [1:0]         lvl_q;
  logic [CNT_W-1:0]   rd_cnt_q;

  logic [AW-1:0]      ctx_addr;
  logic [AW-1:0]      tbl_addr;
  logic [1:0]         next_lvl;
  walk_act_e          act;
  logic [PPN_W-1:0]   ppn_comb;

  assign next_lvl = lvl_q + 2'd1;

  pt_addr_gen #(
    .AW(AW), .CTX_W(CTX_W), .L1_W(L1_W), .L2_W(L2_W), .L3_W(L3_W), .FLAG_W(FLAG_W)
  ) u_addr (
    .ctx_base_i (ctx_base),
    .ctx_i      (miss_ctx),
    .tbl_hi_i   (mem_rsp_data[AW-1:FLAG_W]),
    .vpn_i      (vpn_q),
    .next_lvl_i (next_lvl),
    .ctx_addr_o (ctx_addr),
    .tbl_addr_o (tbl_addr)
  );

  pt_entry_classify u_cls (
    .kind_bits_i (mem_rsp_data[1:0]),
    .lvl_i       (lvl_q),
    .act_o       (act)
  );

  pt_ppn_compose #(
    .PPN_W(PPN_W), .L2_W(L2_W), .L3_W(L3_W)
  ) u_ppn (
    .leaf_ppn_i (mem_rsp_data[AW-1:FLAG_W]),
    .vpn_lo_i   (vpn_q[LO_W-1:0]),
    .lvl_i      (lvl_q),
    .ppn_o      (ppn_comb)
  );

  assign busy = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      vpn_q         <= '0;
      lvl_q         <= '0;
      rd_cnt_q      <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      done_valid    <= 1'b0;
      done_fault    <= 1'b0;
      done_level    <= '0;
      done_ppn      <= '0;
      done_flags    <= '0;
    end else begin
      mem_req_valid <= 1'b0;
      done_valid    <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (miss_valid) begin
            vpn_q         <= miss_vpn;
            lvl_q         <= 2'd0;
            rd_cnt_q      <= CNT_W'(1);
            mem_req_addr  <= ctx_addr;
            mem_req_valid <= 1'b1;
            state_q       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            unique case (act)
              ACT_DESCEND: begin
                lvl_q         <= next_lvl;
                rd_cnt_q      <= rd_cnt_q + CNT_W'(1);
                mem_req_addr  <= tbl_addr;
                mem_req_valid <= 1'b1;
              end
              ACT_LEAF: begin
                done_valid <= 1'b1;
                done_fault <= 1'b0;
                done_level <= lvl_q;
                done_ppn   <= ppn_comb;
                done_flags <= mem_rsp_data[FLAG_W-1:0];
                state_q    <= ST_RESP;
              end
              default: begin
                done_valid <= 1'b1;
                done_fault <= 1'b1;
                done_level <= lvl_q;
                done_ppn   <= '0;
                done_flags <= '0;
                state_q    <= ST_RESP;
              end
            endcase
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  result_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> busy);

  // R10
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);

  // R9
  read_budget_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (rd_cnt_q >= CNT_W'(1) && rd_cnt_q <= CNT_W'(MAX_RD)));

  // R9
  reads_match_level_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> (rd_cnt_q == CNT_W'(done_level) + CNT_W'(1)));

  // R5
  fault_clears_payload_chk: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_fault) |-> (done_ppn == '0 && done_flags == '0));

  // R5
  no_leaf_at_root_chk: assert property (@(posedge clk) disable iff (rst)
    (done_valid && !done_fault) |-> (done_level != 2'd0));

  // R7
  region_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (done_valid && !done_fault && done_level == 2'd1) |-> (done_ppn[LO_W-1:0] == vpn_q[LO_W-1:0]));

  // R9
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ctx_base = 32'h0;
  logic        miss_valid = 1'b0;
  logic [7:0]  miss_ctx = 8'h0;
  logic [19:0] miss_vpn = 20'h0;
  logic        busy;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = 32'h0;
  logic        done_valid;
  logic        done_fault;
  logic [1:0]  done_level;
  logic [23:0] done_ppn;
  logic [7:0]  done_flags;

  always #4 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst(rst), .ctx_base(ctx_base),
    .miss_valid(miss_valid), .miss_ctx(miss_ctx), .miss_vpn(miss_vpn),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_valid(done_valid), .done_fault(done_fault), .done_level(done_level),
    .done_ppn(done_ppn), .done_flags(done_flags)
  );

  logic [31:0] mem [0:2047];
  int          n_chk = 0;
  int          n_fail = 0;
  int          n_rd = 0;
  logic [31:0] got_addr [0:7];
  bit          finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Memory responder: one outstanding read, latency 1..4 cycles
  initial begin
    @(negedge clk);
    forever begin
      if (mem_req_valid) begin
        logic [31:0] a;
        a = mem_req_addr;
        if (n_rd < 8) got_addr[n_rd] = a;
        n_rd++;
        repeat (1 + int'(a[3:2])) @(negedge clk);
        mem_rsp_data  = mem[a[12:2]];
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  // Reference walk derived from R3..R7
  task automatic model(input logic [7:0] ctx, input logic [19:0] vpn,
                       output bit f, output logic [23:0] ppn, output logic [7:0] fl,
                       output int lvl, output logic [31:0] addrs [0:3]);
    logic [31:0] a, e, idx;
    bit stop;
    a = ctx_base + 32'(ctx) * 4;
    lvl = 0; stop = 0; f = 1; ppn = 0; fl = 0;
    while (!stop) begin
      addrs[lvl] = a;
      e = mem[a[12:2]];
      if (e[1:0] == 2'd1 && lvl < 3) begin
        idx = (lvl == 0) ? 32'(vpn[19:12]) : (lvl == 1) ? 32'(vpn[11:6]) : 32'(vpn[5:0]);
        a = {e[31:8], 8'h00} + idx * 4;
        lvl++;
      end else begin
        stop = 1;
        if (e[1:0] == 2'd2 && lvl > 0) begin
          f = 0;
          fl = e[7:0];
          if (lvl == 1)      ppn = {e[31:20], vpn[11:0]};
          else if (lvl == 2) ppn = {e[31:14], vpn[5:0]};
          else               ppn = e[31:8];
        end
      end
    end
  endtask

  task automatic run_walk(input logic [7:0] ctx, input logic [19:0] vpn, input bit stall);
    bit f; logic [23:0] ppn; logic [7:0] fl; int lvl; logic [31:0] ea [0:3];
    int wait_cyc;
    string rq;
    model(ctx, vpn, f, ppn, fl, lvl, ea);
    n_rd = 0;
    @(negedge clk);
    miss_valid = 1'b1; miss_ctx = ctx; miss_vpn = vpn;
    @(negedge clk);
    check(busy === 1'b1, "R2", "busy after accept", 32'(busy), 32'h1);
    if (stall) begin
      miss_ctx = ctx ^ 8'h01; miss_vpn = ~vpn;
    end else begin
      miss_valid = 1'b0;
    end
    wait_cyc = 0;
    while (done_valid !== 1'b1 && wait_cyc < 200) begin
      @(negedge clk);
      wait_cyc++;
    end
    check(done_valid === 1'b1, "R9", "walk completes", 32'(done_valid), 32'h1);
    check(done_fault === f, "R5", "fault flag", 32'(done_fault), 32'(f));
    check(done_level === 2'(lvl), "R5", "end level", 32'(done_level), 32'(lvl));
    rq = (lvl == 3) ? "R6" : "R7";
    check(done_ppn === ppn, f ? "R5" : rq, "ppn", 32'(done_ppn), 32'(ppn));
    check(done_flags === fl, f ? "R5" : rq, "flags", 32'(done_flags), 32'(fl));
    check(n_rd == lvl + 1, "R9", "read count", 32'(n_rd), 32'(lvl + 1));
    check(got_addr[0] === ea[0], "R2", "context read address", got_addr[0], ea[0]);
    for (int i = 1; i <= lvl && i < 4; i++)
      check(got_addr[i] === ea[i], "R3", "table read address", got_addr[i], ea[i]);
    check(busy === 1'b1, "R8", "busy during result", 32'(busy), 32'h1);
    miss_valid = 1'b0;
    @(negedge clk);
    check(done_valid === 1'b0, "R10", "result pulse width", 32'(done_valid), 32'h0);
    check(busy === 1'b0, "R8", "busy drops after result", 32'(busy), 32'h0);
    if (stall) begin
      @(negedge clk);
      check(n_rd == lvl + 1, "R8", "held miss started no walk", 32'(n_rd), 32'(lvl + 1));
    end
  endtask

  task automatic fill_tables();
    for (int w = 0; w < 2048; w++) mem[w] = 32'h0;
    // context table at 0x0000
    mem[0] = {24'h000004, 8'h01};
    mem[1] = {24'h000008, 8'h01};
    mem[2] = 32'h0;
    mem[3] = {24'hC0FFEE, 8'h03};
    mem[4] = {24'h123456, 8'h02};
    // level-1 table at 0x0400
    for (int i = 0; i < 256; i++) begin
      logic [23:0] p;
      p = 24'h5A5A5A ^ (24'(i) * 24'h010203);
      unique case (i % 4)
        0: mem[256 + i] = {24'h000010, 8'h01};
        1: mem[256 + i] = {p, 6'(i * 13), 2'b10};
        2: mem[256 + i] = 32'h0;
        default: mem[256 + i] = {p, 8'hFF};
      endcase
    end
    // second level-1 table at 0x0800
    mem[512 + 5] = {24'h000010, 8'h01};
    // level-2 table at 0x1000
    for (int j = 0; j < 64; j++) begin
      logic [23:0] p;
      p = 24'hA3C5E7 ^ (24'(j) * 24'h030507);
      unique case (j % 3)
        0: mem[1024 + j] = {24'h000014, 8'h01};
        1: mem[1024 + j] = {p, 6'(j * 7), 2'b10};
        default: mem[1024 + j] = 32'h0;
      endcase
    end
    // level-3 table at 0x1400
    for (int k = 0; k < 64; k++) begin
      logic [23:0] p;
      p = 24'h0F1E2D + (24'(k) * 24'h011111);
      unique case (k % 4)
        1: mem[1280 + k] = 32'h0;
        3: mem[1280 + k] = {24'h000010, 8'h01};
        default: mem[1280 + k] = {p, 6'(k * 5 + 1), 2'b10};
      endcase
    end
  endtask

  initial begin
    fill_tables();
    repeat (3) @(negedge clk);
    // R1
    check(busy === 1'b0, "R1", "busy in reset", 32'(busy), 32'h0);
    check(mem_req_valid === 1'b0, "R1", "req in reset", 32'(mem_req_valid), 32'h0);
    check(done_valid === 1'b0, "R1", "done in reset", 32'(done_valid), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0, "R1", "busy after reset", 32'(busy), 32'h0);

    // R4 every kind at level 1, all 256 indices
    for (int i = 0; i < 256; i++)
      run_walk(8'd0, {8'(i), 6'(i * 5), 6'(i * 11 + 2)}, 1'b0);
    // every level-2 index under a level-1 pointer
    for (int j = 0; j < 64; j++)
      run_walk(8'd0, {8'd0, 6'(j), 6'(j * 3 + 1)}, 1'b0);
    // every level-3 index
    for (int k = 0; k < 64; k++)
      run_walk(8'd0, {8'd4, 6'd0, 6'(k)}, 1'b0);
    // other contexts: second root, invalid, reserved, leaf at root, unset
    run_walk(8'd1, {8'd5, 6'd3, 6'd8}, 1'b0);
    run_walk(8'd1, {8'd5, 6'd4, 6'd1}, 1'b0);
    run_walk(8'd1, {8'd6, 6'd3, 6'd8}, 1'b0);
    run_walk(8'd2, 20'h12345, 1'b0);
    run_walk(8'd3, 20'h0ABCD, 1'b0);
    run_walk(8'd4, 20'hFFFFF, 1'b0);
    run_walk(8'd200, 20'h00001, 1'b0);
    // R8 miss held high during walks
    run_walk(8'd0, {8'd8, 6'd9, 6'd2}, 1'b1);
    run_walk(8'd0, {8'd13, 6'd7, 6'd0}, 1'b1);
    run_walk(8'd0, {8'd0, 6'd0, 6'd3}, 1'b1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule